// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block is a calendar clock whose registers sit in the eight highest byte addresses of a 13-bit byte address space. It keeps century, year, month, date, day of week, hour, minute and second in packed BCD. A single-cycle pulse on `tick` advances the time by one second. Month lengths and leap days are corrected automatically.

Two copies of the time exist. The counter copy always runs. The user copy is what the byte bus reads and writes. Two control bits in the control/century register decide how the copies interact:

- The freeze bit holds the user copy steady for a consistent read while the counters keep counting.
- The set bit lets software write a new time into the user copy. Clearing the set bit then transfers that time into the counters.

Register offsets within the window: 0 control/century, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year.

Top module: `bcdCalendarRtc`

## Requirements
- R1: An access is in the window only when address bits 12..3 are all ones. An enabled read outside the window, or with `busWe` high, returns 0x00. A write outside the window changes no register.
- R2: Offset 0 reads as {set bit (bit 7), freeze bit (bit 6), century BCD (bits 5..0)}. Offsets 1..7 read as seconds, minutes, hours, day of week, date, month and year. The day-of-week byte reads as bit 7 = 1, bits 6..3 = 0 and the day (1..7) in bits 2..0.
- R3: While both control bits are 0, each tick advances the counters by one second. The user copy shows the new time from the cycle after the tick.
- R4: Seconds and minutes wrap 59→00 and hours wrap 23→00, each carrying into the next field. On a day change the day of week steps 7→1, otherwise it adds one.
- R5: The date wraps to 01 and carries into the month after 30 in months 04, 06, 09 and 11. It does so after 31 in the other months, and after 28 in month 02 of a non-leap year.
- R6: A year whose BCD value is divisible by 4 is a leap year, year 00 included. In a leap year, 02-28 steps to 02-29 and 02-29 steps to 03-01.
- R7: Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and increments the century. So 31 Dec xx99 23:59:59 steps to 01 Jan (xx+1)00 00:00:00.
- R8: While the freeze bit is 1, the user copy does not change, but the counters keep counting ticks. After the freeze bit is cleared, the next tick shows the counter value including every tick counted during the freeze.
- R9: While the set bit is 1, writes to offsets 1..7 store the data into the user copy and read back, with fields masked to their BCD width. Ticks do not change the user copy.
- R10: While the set bit is 0, writes to offsets 1..7 are ignored. A write to offset 0 with the set bit 0 updates only the two control bits, not the century.
- R11: A write to offset 0 that clears a set bit of 1 stores bits 5..0 as the century and loads the whole user copy into the counters. A tick in that same cycle is discarded. Counting resumes from the loaded time at the next tick.
- R12: After reset, both control bits are 0 and the time reads century 20, year 00, month 01, date 01, day 1, 00:00:00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second pulse, one cycle wide |
| busEn | input | 1 | Bus access enable |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 13 | Byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |

## Verification
Two functions can land in the same cycle: a tick advancing the counters, and a write that clears the set bit and loads the user copy into the counters. The bench drives both on the same clock edge. It then checks that the seconds field reads back exactly the written value, and that it is only one count higher after one more tick. A tick that slipped through would leave it two counts higher. A second pairing, releasing the freeze bit without a refresh until the next tick, is judged by reading the frozen value before that tick and the caught-up value after it.

// File: rtl/rtcPkg.sv
package rtcPkg;

  localparam int FIELD_W = 8;
  localparam int OFS_W   = 3;

  typedef struct packed {
    logic [FIELD_W-1:0] cent;
    logic [FIELD_W-1:0] year;
    logic [FIELD_W-1:0] month;
    logic [FIELD_W-1:0] date;
    logic [FIELD_W-1:0] dow;
    logic [FIELD_W-1:0] hour;
    logic [FIELD_W-1:0] minute;
    logic [FIELD_W-1:0] sec;
  } calTime_t;

  localparam calTime_t CAL_RESET = '{cent: 8'h20, year: 8'h00, month: 8'h01,
                                     date: 8'h01, dow: 8'h01, hour: 8'h00,
                                     minute: 8'h00, sec: 8'h00};

  typedef struct packed {
    logic             inWindow;
    logic             wbit;
    logic             rbit;
    logic             loadCnt;
    logic             refreshUser;
    logic             wrField;
    logic [OFS_W-1:0] fieldSel;
    logic [7:0]       wrData;
  } rtcStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    return (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : v + 8'h01;
  endfunction

  function automatic logic isLeap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    else       return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
  endfunction

  function automatic logic [7:0] monthLast(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return isLeap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/calNext.sv
module calNext
  import rtcPkg::*;
(
  input  calTime_t cur,
  output calTime_t nxt
);
  logic cMin, cHour, cDay, cMon, cYear, cCent;

  always_comb begin
    cMin  = cur.sec >= 8'h59;
    cHour = cMin && (cur.minute >= 8'h59);
    cDay  = cHour && (cur.hour >= 8'h23);
    cMon  = cDay && (cur.date >= monthLast(cur.month, cur.year));
    cYear = cMon && (cur.month >= 8'h12);
    cCent = cYear && (cur.year >= 8'h99);

    nxt        = cur;
    nxt.sec    = cMin ? 8'h00 : bcdInc(cur.sec);
    if (cMin)  nxt.minute = cHour ? 8'h00 : bcdInc(cur.minute);
    if (cHour) nxt.hour   = cDay ? 8'h00 : bcdInc(cur.hour);
    if (cDay) begin
      nxt.dow  = (cur.dow >= 8'h07) ? 8'h01 : cur.dow + 8'h01;
      nxt.date = cMon ? 8'h01 : bcdInc(cur.date);
    end
    if (cMon)  nxt.month = cYear ? 8'h01 : bcdInc(cur.month);
    if (cYear) nxt.year  = cCent ? 8'h00 : bcdInc(cur.year);
    if (cCent) nxt.cent  = (cur.cent >= 8'h39) ? 8'h00 : bcdInc(cur.cent);
  end
endmodule

// File: rtl/rtcCtrl.sv
module rtcCtrl
  import rtcPkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output rtcStrobe_t        strb
);
  localparam int TAG_W = ADDR_W - OFS_W;

  logic wbitQ, rbitQ, wr, ctlWr;

  always_comb begin
    strb.inWindow    = busEn && (busAddr[ADDR_W-1:OFS_W] == {TAG_W{1'b1}});
    wr               = strb.inWindow && busWe;
    ctlWr            = wr && (busAddr[OFS_W-1:0] == '0);
    strb.wbit        = wbitQ;
    strb.rbit        = rbitQ;
    strb.wrField     = wr && wbitQ;
    strb.fieldSel    = busAddr[OFS_W-1:0];
    strb.wrData      = busWdata;
    strb.loadCnt     = ctlWr && wbitQ && !busWdata[7];
    strb.refreshUser = tick && !wbitQ && !rbitQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbitQ <= 1'b0;
      rbitQ <= 1'b0;
    end else if (ctlWr) begin
      wbitQ <= busWdata[7];
      rbitQ <= busWdata[6];
    end
  end

  p_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadCnt && strb.refreshUser));
  p_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> !wbitQ);
endmodule

// File: rtl/rtcData.sv
module rtcData
  import rtcPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  rtcStrobe_t       strb,
  input  logic [OFS_W-1:0] rdOfs,
  output logic [7:0]       rdData
);
  calTime_t userQ, cntQ, userNext, cntInc;

  calNext nextCal_i (.cur(cntQ), .nxt(cntInc));

  always_comb begin
    userNext = userQ;
    if (strb.wrField) begin
      case (strb.fieldSel)
        3'd0: userNext.cent   = strb.wrData & 8'h3F;
        3'd1: userNext.sec    = strb.wrData & 8'h7F;
        3'd2: userNext.minute = strb.wrData & 8'h7F;
        3'd3: userNext.hour   = strb.wrData & 8'h3F;
        3'd4: userNext.dow    = strb.wrData & 8'h07;
        3'd5: userNext.date   = strb.wrData & 8'h3F;
        3'd6: userNext.month  = strb.wrData & 8'h1F;
        default: userNext.year = strb.wrData;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      userQ <= CAL_RESET;
      cntQ  <= CAL_RESET;
    end else begin
      userQ <= strb.refreshUser ? cntInc : userNext;
      if (strb.loadCnt)  cntQ <= userNext;
      else if (tick)     cntQ <= cntInc;
    end
  end

  always_comb begin
    case (rdOfs)
      3'd0: rdData = {strb.wbit, strb.rbit, userQ.cent[5:0]};
      3'd1: rdData = userQ.sec;
      3'd2: rdData = userQ.minute;
      3'd3: rdData = userQ.hour;
      3'd4: rdData = {5'b10000, userQ.dow[2:0]};
      3'd5: rdData = userQ.date;
      3'd6: rdData = userQ.month;
      default: rdData = userQ.year;
    endcase
  end

  p_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.refreshUser |=> (userQ == cntQ));
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rbit && !strb.wbit) |=> $stable(userQ));
  p_load_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> (cntQ == userQ));
  p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strb.loadCnt && cntQ.sec == 8'h59) |=> (cntQ.sec == 8'h00));
  p_dow_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strb.loadCnt && cntQ.dow == 8'h07 && cntQ.hour == 8'h23 &&
     cntQ.minute == 8'h59 && cntQ.sec == 8'h59) |=> (cntQ.dow == 8'h01));
endmodule

// File: rtl/bcdCalendarRtc.sv
module bcdCalendarRtc
  import rtcPkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata
);
  rtcStrobe_t strb;
  logic [7:0] regData;

  rtcCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .busEn(busEn), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .strb(strb));

  rtcData data_i (
    .clk(clk), .rstN(rstN), .tick(tick), .strb(strb),
    .rdOfs(busAddr[OFS_W-1:0]), .rdData(regData));

  assign busRdata = (strb.inWindow && !busWe) ? regData : 8'h00;
endmodule

// File: tb/bcdCalendarRtc_tb.sv
module bcdCalendarRtc_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        busEn = 1'b0;
  logic        busWe = 1'b0;
  logic [12:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  int          nRun = 0;
  int          nFail = 0;

  localparam logic [12:0] WIN = 13'h1FF8;

  always #2 clk = ~clk;

  bcdCalendarRtc dut_i (.clk(clk), .rstN(rstN), .tick(tick), .busEn(busEn),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata));

  task automatic checkByte(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [12:0] a, input logic [7:0] d, input logic withTick);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d; tick = withTick;
    @(negedge clk);
    busEn = 1'b0; busWe = 1'b0; tick = 1'b0;
  endtask

  task automatic busRead(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b0; busAddr = a;
    #1 d = busRdata;
    busEn = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic expectReg(input string tag, input logic [2:0] ofs, input logic [7:0] exp);
    logic [7:0] d;
    busRead(WIN | 13'(ofs), d);
    checkByte(tag, d, exp);
  endtask

  // offsets: 0 ctl/century, 1 sec, 2 min, 3 hour, 4 dow, 5 date, 6 month, 7 year
  task automatic setTime(input logic [7:0] c, y, mo, dt, dw, h, mi, s);
    busWrite(WIN, 8'h80, 1'b0);
    busWrite(WIN | 13'd1, s, 1'b0);
    busWrite(WIN | 13'd2, mi, 1'b0);
    busWrite(WIN | 13'd3, h, 1'b0);
    busWrite(WIN | 13'd4, dw, 1'b0);
    busWrite(WIN | 13'd5, dt, 1'b0);
    busWrite(WIN | 13'd6, mo, 1'b0);
    busWrite(WIN | 13'd7, y, 1'b0);
    busWrite(WIN, c & 8'h3F, 1'b0);
  endtask

  task automatic expectTime(input string tag, input logic [7:0] c, y, mo, dt, dw, h, mi, s);
    expectReg({tag, " century"}, 3'd0, c);
    expectReg({tag, " year"}, 3'd7, y);
    expectReg({tag, " month"}, 3'd6, mo);
    expectReg({tag, " date"}, 3'd5, dt);
    expectReg({tag, " dow"}, 3'd4, 8'h80 | dw);
    expectReg({tag, " hour"}, 3'd3, h);
    expectReg({tag, " minute"}, 3'd2, mi);
    expectReg({tag, " second"}, 3'd1, s);
  endtask

  task automatic testReset();
    logic [7:0] d;
    expectTime("R12 R2 reset", 8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    busRead(13'h0000, d);
    checkByte("R1 read outside window", d, 8'h00);
    busRead(13'h1FF7, d);
    checkByte("R1 read just below window", d, 8'h00);
  endtask

  task automatic testTickAndIgnore();
    pulse(3);
    expectReg("R3 three ticks", 3'd1, 8'h03);
    busWrite(WIN | 13'd1, 8'h45, 1'b0);
    expectReg("R10 sec write with set bit 0", 3'd1, 8'h03);
    busWrite(WIN, 8'h15, 1'b0);
    expectReg("R10 century ignored without set bit", 3'd0, 8'h20);
  endtask

  task automatic testRollovers();
    setTime(8'h19, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    pulse(1);
    expectTime("R7 year end", 8'h20, 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00);
    setTime(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    pulse(1);
    expectReg("R6 leap 28 to 29 date", 3'd5, 8'h29);
    expectReg("R6 leap 28 to 29 month", 3'd6, 8'h02);
    setTime(8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
    pulse(1);
    expectReg("R6 leap 29 to 01 date", 3'd5, 8'h01);
    expectReg("R6 leap 29 to 03 month", 3'd6, 8'h03);
    setTime(8'h21, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse(1);
    expectReg("R6 year 00 is leap", 3'd5, 8'h29);
    setTime(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    pulse(1);
    expectReg("R5 non-leap Feb date", 3'd5, 8'h01);
    expectReg("R5 non-leap Feb month", 3'd6, 8'h03);
    setTime(8'h20, 8'h23, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    pulse(1);
    expectReg("R5 April 30 date", 3'd5, 8'h01);
    expectReg("R5 April 30 month", 3'd6, 8'h05);
    setTime(8'h20, 8'h23, 8'h11, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    pulse(1);
    expectReg("R5 November 30 month", 3'd6, 8'h12);
    setTime(8'h20, 8'h23, 8'h01, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    pulse(1);
    expectReg("R5 January 30 to 31", 3'd5, 8'h31);
    setTime(8'h20, 8'h23, 8'h05, 8'h10, 8'h07, 8'h23, 8'h59, 8'h59);
    pulse(1);
    expectReg("R4 dow 7 to 1", 3'd4, 8'h81);
    expectReg("R4 hour 23 wrap", 3'd3, 8'h00);
    setTime(8'h20, 8'h23, 8'h05, 8'h10, 8'h03, 8'h10, 8'h59, 8'h59);
    pulse(1);
    expectTime("R4 minute carry", 8'h20, 8'h23, 8'h05, 8'h10, 8'h03, 8'h11, 8'h00, 8'h00);
  endtask

  task automatic testFreeze();
    setTime(8'h20, 8'h23, 8'h06, 8'h01, 8'h04, 8'h08, 8'h00, 8'h00);
    busWrite(WIN, 8'h40, 1'b0);
    expectReg("R2 R8 freeze bit visible", 3'd0, 8'h60);
    pulse(5);
    expectReg("R8 frozen second", 3'd1, 8'h00);
    busWrite(WIN, 8'h00, 1'b0);
    expectReg("R8 no refresh before tick", 3'd1, 8'h00);
    pulse(1);
    expectReg("R8 caught up after tick", 3'd1, 8'h06);
  endtask

  task automatic testSetCollision();
    setTime(8'h20, 8'h23, 8'h06, 8'h01, 8'h04, 8'h12, 8'h00, 8'h00);
    busWrite(WIN, 8'h80, 1'b0);
    expectReg("R2 R9 set bit visible", 3'd0, 8'hA0);
    pulse(2);
    busWrite(WIN | 13'd1, 8'h10, 1'b0);
    busWrite(WIN | 13'd4, 8'hFF, 1'b0);
    pulse(1);
    expectReg("R9 written second held over tick", 3'd1, 8'h10);
    expectReg("R9 dow masked", 3'd4, 8'h87);
    busWrite(13'h0FF9, 8'h33, 1'b0);
    expectReg("R1 write outside window ignored", 3'd1, 8'h10);
    busWrite(WIN, 8'h21, 1'b1);
    expectReg("R11 loaded second, tick discarded", 3'd1, 8'h10);
    expectReg("R11 century from release write", 3'd0, 8'h21);
    pulse(1);
    expectReg("R11 counting resumes", 3'd1, 8'h11);
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTickAndIgnore();
    testRollovers();
    testFreeze();
    testSetCollision();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule